// File: doc/BRIEF.md
# Power-Good Latch and Power-Down Sequencer

This block owns a single control pin that changes meaning once during the life of a clock generator. After reset the pin is read as an active-low power-good. The first time it is sampled low, the two frequency-select inputs are captured into a frequency code. That code is then frozen against any further activity on the select inputs or on the pin. From that moment the same pin is read as an active-high power-down request.

The sequencer is a five-state machine. The states are WAIT_PGOOD, WAIT_LOCK, RUN, HOLD_OUTPUTS and POWERED_DOWN. The named transitions are:
- **pgood_seen**: WAIT_PGOOD to WAIT_LOCK.
- **locked**: WAIT_LOCK to RUN.
- **pd_at_fall**: RUN to HOLD_OUTPUTS, taken on a qualified request together with an output falling-transition strobe.
- **hold_done**: HOLD_OUTPUTS to POWERED_DOWN, taken after a fixed dwell.
- **pd_release**: POWERED_DOWN to WAIT_LOCK.
- **pd_relock_abort**: WAIT_LOCK to POWERED_DOWN.

While the outputs are held, the oscillator and PLLs stay enabled. They are switched off only once the hold dwell has elapsed. On release, the enables return at once, but the output hold drops only after the PLL lock input is seen. A counter sized to the restart budget raises a sticky error if lock does not arrive in time. A test-mode input reopens the frequency latch.

Top module: `pgood_pdn_seq`

## Requirements
- R1: After reset: out_hold=1, osc_en=1, pll_en=1, code_valid=0, lock_err=0, and the state is WAIT_PGOOD.
- R2: The first rising clock edge that samples ctl_pin low captures fsel into freq_code, and code_valid rises at the following edge. fsel[1] is the high select bit and fsel[0] the low one. The codes map as 2'b10=100 MHz, 2'b00=133 MHz, 2'b01=166 MHz and 2'b11=200 MHz.
- R3: Once code_valid is 1 and test_mode is 0, changes on fsel and toggles on ctl_pin leave freq_code unchanged.
- R4: While test_mode=1 and ctl_pin is sampled low, freq_code takes the value of fsel two clock edges after fsel is applied.
- R5: In WAIT_LOCK, out_hold stays 1 until pll_lock is sampled high. out_hold is 0 after the next edge.
- R6: In RUN, a power-down request needs ctl_pin high on two consecutive rising edges. A high pulse that lasts one cycle leaves out_hold at 0.
- R7: A qualified power-down raises out_hold only at an edge where out_fall is 1. pll_en is still 1 at that point.
- R8: osc_en and pll_en fall HOLD_CYC edges after the edge that raised out_hold.
- R9: In POWERED_DOWN, ctl_pin sampled low at one edge restores osc_en and pll_en at the next edge. out_hold stays 1.
- R10: lock_err rises LOCK_CYCLES edges after WAIT_LOCK is entered if pll_lock stays low. It then stays 1 until reset.
- R11: A qualified power-down request in WAIT_LOCK moves the block straight to POWERED_DOWN, with osc_en and pll_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (CPU clock domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pin | input | 1 | Dual-role pin: power-good (low) before capture, power-down request (high) after |
| fsel | input | 2 | Frequency select inputs |
| test_mode | input | 1 | Reopens the frequency latch when high |
| pll_lock | input | 1 | Lock report from the PLLs |
| out_fall | input | 1 | Strobe marking a falling transition of the clock outputs |
| freq_code | output | 2 | Latched frequency code, read-only status |
| code_valid | output | 1 | Frequency code has been captured |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL/VCO enable |
| out_hold | output | 1 | Forces clock outputs to their held level |
| lock_err | output | 1 | Sticky lock-timeout flag |

## Verification
The assertions assume that pll_lock and out_fall are synchronous to clk. They also assume that HOLD_CYC does not exceed LOCK_CYCLES, so the shared dwell counter reaches the hold limit before it saturates. The ordering checks further assume that lock is never reported while the PLLs are disabled. The stimulus drives every input at the falling clock edge and samples outputs there too. It drops pll_lock whenever the block powers down and raises it only while the block waits for lock.

// File: rtl/pgs_pkg.sv
`timescale 1ns/1ps
package pgs_pkg;
    localparam int FSEL_W = 2;

    typedef enum logic [2:0] {
        ST_WAIT_PGOOD   = 3'd0,
        ST_WAIT_LOCK    = 3'd1,
        ST_RUN          = 3'd2,
        ST_HOLD_OUTPUTS = 3'd3,
        ST_POWERED_DOWN = 3'd4
    } pgs_state_t;

    localparam logic [FSEL_W-1:0] FREQ_100 = 2'b10;
    localparam logic [FSEL_W-1:0] FREQ_133 = 2'b00;
    localparam logic [FSEL_W-1:0] FREQ_166 = 2'b01;
    localparam logic [FSEL_W-1:0] FREQ_200 = 2'b11;
endpackage

// File: rtl/pgs_pin_sampler.sv
`timescale 1ns/1ps
module pgs_pin_sampler
    import pgs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_pin,
    input  logic [FSEL_W-1:0] fsel,
    input  logic              test_mode,
    output logic              pin_low,
    output logic              pd_req,
    output logic [FSEL_W-1:0] fsel_q,
    output logic              test_q
);
    logic samp_now;
    logic samp_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_now  <= 1'b1;
            samp_prev <= 1'b1;
            fsel_q    <= '0;
            test_q    <= 1'b0;
        end else begin
            samp_now  <= ctl_pin;
            samp_prev <= samp_now;
            fsel_q    <= fsel;
            test_q    <= test_mode;
        end
    end

    assign pin_low = ~samp_now;
    assign pd_req  = samp_now & samp_prev;
endmodule

// File: rtl/pgs_fsel_latch.sv
`timescale 1ns/1ps
module pgs_fsel_latch
    import pgs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_load,
    input  logic              test_q,
    input  logic              pin_low,
    input  logic [FSEL_W-1:0] fsel_q,
    output logic [FSEL_W-1:0] code,
    output logic              valid
);
    logic reload;

    assign reload = first_load | (test_q & pin_low);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code  <= FREQ_133;
            valid <= 1'b0;
        end else begin
            if (reload) begin
                code <= fsel_q;
            end
            if (first_load) begin
                valid <= 1'b1;
            end
        end
    end

    assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid);

    assert_code_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !test_q) |=> $stable(code));
endmodule

// File: rtl/pgs_seq_fsm.sv
`timescale 1ns/1ps
module pgs_seq_fsm
    import pgs_pkg::*;
#(
    parameter int HOLD_CYC    = 8,
    parameter int LOCK_CYCLES = 360000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_low,
    input  logic pd_req,
    input  logic out_fall,
    input  logic pll_lock,
    output logic first_load,
    output logic osc_en,
    output logic pll_en,
    output logic out_hold,
    output logic lock_err
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYCLES - 1);

    pgs_state_t       state;
    pgs_state_t       state_nxt;
    logic [CNT_W-1:0] dwell;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT_PGOOD:   if (pin_low)             state_nxt = ST_WAIT_LOCK;
            ST_WAIT_LOCK:    if (pd_req)              state_nxt = ST_POWERED_DOWN;
                             else if (pll_lock)       state_nxt = ST_RUN;
            ST_RUN:          if (pd_req && out_fall)  state_nxt = ST_HOLD_OUTPUTS;
            ST_HOLD_OUTPUTS: if (dwell == HOLD_LAST)  state_nxt = ST_POWERED_DOWN;
            ST_POWERED_DOWN: if (pin_low)             state_nxt = ST_WAIT_LOCK;
            default:                                  state_nxt = ST_WAIT_PGOOD;
        endcase
    end

    // state register, dwell counter and lock timeout
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_WAIT_PGOOD;
            dwell    <= '0;
            lock_err <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state_nxt != state) begin
                dwell <= '0;
            end else if (dwell != LOCK_LAST) begin
                dwell <= dwell + 1'b1;
            end
            if (state == ST_WAIT_LOCK && !pll_lock && dwell == LOCK_LAST) begin
                lock_err <= 1'b1;
            end
        end
    end

    // Moore outputs
    always_comb begin
        osc_en   = 1'b1;
        pll_en   = 1'b1;
        out_hold = 1'b1;
        unique case (state)
            ST_WAIT_PGOOD:   ;
            ST_WAIT_LOCK:    ;
            ST_RUN:          out_hold = 1'b0;
            ST_HOLD_OUTPUTS: ;
            ST_POWERED_DOWN: begin
                osc_en = 1'b0;
                pll_en = 1'b0;
            end
            default:         ;
        endcase
    end

    assign first_load = (state == ST_WAIT_PGOOD) && pin_low;

    assert_release_after_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_hold) |-> $past(pll_lock));

    assert_pll_off_after_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en) |-> $past(out_hold));

    assert_lock_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |=> lock_err);

    assert_osc_tracks_pll_R9: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en == pll_en);
endmodule

// File: rtl/pgood_pdn_seq.sv
`timescale 1ns/1ps
module pgood_pdn_seq
    import pgs_pkg::*;
#(
    parameter int HOLD_CYC    = 8,
    parameter int LOCK_CYCLES = 360000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_pin,
    input  logic [1:0] fsel,
    input  logic       test_mode,
    input  logic       pll_lock,
    input  logic       out_fall,
    output logic [1:0] freq_code,
    output logic       code_valid,
    output logic       osc_en,
    output logic       pll_en,
    output logic       out_hold,
    output logic       lock_err
);
    logic              pin_low;
    logic              pd_req;
    logic [FSEL_W-1:0] fsel_q;
    logic              test_q;
    logic              first_load;

    pgs_pin_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_pin   (ctl_pin),
        .fsel      (fsel),
        .test_mode (test_mode),
        .pin_low   (pin_low),
        .pd_req    (pd_req),
        .fsel_q    (fsel_q),
        .test_q    (test_q)
    );

    pgs_fsel_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_load (first_load),
        .test_q     (test_q),
        .pin_low    (pin_low),
        .fsel_q     (fsel_q),
        .code       (freq_code),
        .valid      (code_valid)
    );

    pgs_seq_fsm #(
        .HOLD_CYC    (HOLD_CYC),
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_low    (pin_low),
        .pd_req     (pd_req),
        .out_fall   (out_fall),
        .pll_lock   (pll_lock),
        .first_load (first_load),
        .osc_en     (osc_en),
        .pll_en     (pll_en),
        .out_hold   (out_hold),
        .lock_err   (lock_err)
    );
endmodule

// File: tb/pgood_pdn_seq_test.sv
`timescale 1ns/1ps
module pgood_pdn_seq_test;
    localparam int HOLD = 3;
    localparam int LOCKC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_pin = 1'b1;
    logic [1:0] fsel = 2'b01;
    logic       test_mode = 1'b0;
    logic       pll_lock = 1'b0;
    logic       out_fall = 1'b0;
    logic [1:0] freq_code;
    logic       code_valid, osc_en, pll_en, out_hold, lock_err;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // test-mode table: {fsel applied, expected code}
    localparam logic [3:0] TM_VEC [4] = '{4'b10_10, 4'b00_00, 4'b01_01, 4'b11_11};

    always #2.5 clk = ~clk;

    pgood_pdn_seq #(.HOLD_CYC(HOLD), .LOCK_CYCLES(LOCKC)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_pin(ctl_pin), .fsel(fsel),
        .test_mode(test_mode), .pll_lock(pll_lock), .out_fall(out_fall),
        .freq_code(freq_code), .code_valid(code_valid), .osc_en(osc_en),
        .pll_en(pll_en), .out_hold(out_hold), .lock_err(lock_err)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk("R1 out_hold", out_hold, 1);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 pll_en", pll_en, 1);
        chk("R1 code_valid", code_valid, 0);
        chk("R1 lock_err", lock_err, 0);
        rst_n = 1'b1;
        tick(3);
        chk("R1 no capture while pin high", code_valid, 0);

        // power-good: capture 100 MHz code
        fsel = 2'b10; ctl_pin = 1'b0;
        tick(1);
        chk("R2 not yet valid", code_valid, 0);
        tick(1);
        chk("R2 valid", code_valid, 1);
        chk("R2 code 100MHz", freq_code, 2'b10);

        fsel = 2'b11;
        tick(3);
        chk("R3 fsel ignored", freq_code, 2'b10);
        chk("R5 hold while unlocked", out_hold, 1);
        pll_lock = 1'b1;
        tick(1);
        chk("R5 released after lock", out_hold, 0);

        // single-cycle pulse must not qualify
        out_fall = 1'b1; ctl_pin = 1'b1;
        tick(1);
        ctl_pin = 1'b0;
        tick(4);
        chk("R6 pulse ignored", out_hold, 0);
        chk("R3 pin toggle ignored", freq_code, 2'b10);

        // qualified request waits for falling strobe
        out_fall = 1'b0; ctl_pin = 1'b1;
        tick(6);
        chk("R7 waits for strobe", out_hold, 0);
        out_fall = 1'b1;
        tick(1);
        out_fall = 1'b0; pll_lock = 1'b0;
        chk("R7 hold on strobe", out_hold, 1);
        chk("R7 pll still on", pll_en, 1);
        tick(HOLD - 1);
        chk("R8 pll on before dwell end", pll_en, 1);
        tick(1);
        chk("R8 pll off", pll_en, 0);
        chk("R8 osc off", osc_en, 0);

        // release
        ctl_pin = 1'b0;
        tick(1);
        chk("R9 still down", osc_en, 0);
        tick(1);
        chk("R9 osc back", osc_en, 1);
        chk("R9 pll back", pll_en, 1);
        chk("R9 hold kept", out_hold, 1);

        // re-request during relock
        ctl_pin = 1'b1;
        tick(2);
        chk("R11 not yet", osc_en, 1);
        tick(1);
        chk("R11 straight down", osc_en, 0);
        chk("R11 pll down", pll_en, 0);

        // release without lock: timeout
        ctl_pin = 1'b0;
        tick(2);
        chk("R9 relock entered", pll_en, 1);
        tick(LOCKC - 1);
        chk("R10 no error yet", lock_err, 0);
        tick(1);
        chk("R10 error raised", lock_err, 1);
        pll_lock = 1'b1;
        tick(1);
        chk("R5 release late lock", out_hold, 0);
        chk("R10 error sticky", lock_err, 1);
        chk("R3 code kept", freq_code, 2'b10);

        // test mode table
        test_mode = 1'b1;
        foreach (TM_VEC[i]) begin
            fsel = TM_VEC[i][3:2];
            tick(2);
            chk("R4 test-mode reload", freq_code, {30'd0, TM_VEC[i][1:0]});
        end
        test_mode = 1'b0;
        tick(1);
        fsel = 2'b00;
        tick(3);
        chk("R3 frozen after test", freq_code, 2'b11);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule